// File: doc/BRIEF.md
# Return-from-interrupt status restore

This block computes the machine status word and the next fetch address when a processor retires a return-from-interrupt instruction. It takes the current 64-bit status word, the saved status word that was stored when the interrupt was taken, and the saved return address. The restored status is mostly the saved word. A few fields are merged with the current status instead:

- the machine-check enable follows the current hypervisor state;
- the hypervisor bit can only be cleared on return;
- a transactional-state field is protected against one illegal transition;
- translation and external interrupts are forced on whenever the restored state is the problem (user) state.

The fetch address is the saved return address, aligned to a word boundary. It is truncated to 32 bits when the restored status selects narrow addressing.

A single-cycle strobe starts the calculation. The results are registered and appear one clock later, each with its own valid pulse. There is no back-pressure: the consumer must take the result in the cycle its valid is high. The registered outputs then hold their value until the next strobe.

Bit positions below are numbered from the most significant end of the status word. Position n is vector index 63-n. So position 0 is `msr_o[63]` and position 63 is `msr_o[0]`.

Top module: `rfi_restore`

## Requirements
- R1: Restored position 51 (machine-check enable) takes saved position 51 when current position 3 (hypervisor) is 1, and keeps current position 51 when it is 0.
- R2: Restored position 3 (hypervisor) is the AND of current position 3 and saved position 3.
- R3: Restored positions 29 to 31 (transaction state) take saved positions 29 to 31. The exception is when current positions 29 to 31 equal 0b010 and saved positions 29 to 31 equal 0b000; then the current value 0b010 is kept.
- R4: Restored position 48 (external interrupt enable) is saved position 48 OR saved position 49 (problem state).
- R5: Restored positions 58 (instruction translation) and 59 (data translation) each equal their own saved position OR saved position 49.
- R6: Every other restored position is a direct copy of the same saved position, including position 0 (64-bit mode).
- R7: The fetch address equals the saved return address with vector bits [1:0] forced to 0.
- R8: When restored position 0 is 0, fetch address bits [63:32] are 0. When it is 1, they equal the saved return address bits [63:32].
- R9: Both valid outputs are high in exactly the cycle after a cycle with the start strobe high, and low otherwise. Both are low after reset.
- R10: With no start strobe, the status and address outputs hold their last values. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe: compute a restore from the current inputs |
| cur_msr_i | input | 64 | Current machine status word |
| srr1_i | input | 64 | Status word saved when the interrupt was taken |
| srr0_i | input | 64 | Return address saved when the interrupt was taken |
| msr_o | output | 64 | Restored status word |
| msr_vld_o | output | 1 | Pulses for one cycle when msr_o is updated |
| nia_o | output | 64 | Next fetch address |
| nia_vld_o | output | 1 | Pulses for one cycle when nia_o is updated |

## Verification
The assertions compare each output with the inputs one cycle earlier. They therefore assume the three input words are stable in the strobe cycle, and that the strobe is held low while reset is asserted. The bench drives all inputs on the falling edge, keeps the strobe low throughout reset, and changes the data words only together with a strobe or while idle. The stimulus mixes directed corner words with random words. The transaction-state pair 0b010/0b000 and the problem-state bit are forced often enough that every merge rule is seen in both directions.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int unsigned XLEN = 64;

  // Field positions, numbered from the most significant end of the word
  localparam int unsigned P_SF    = 0;
  localparam int unsigned P_HV    = 3;
  localparam int unsigned P_TS_HI = 29;
  localparam int unsigned P_TS_LO = 31;
  localparam int unsigned P_EE    = 48;
  localparam int unsigned P_PR    = 49;
  localparam int unsigned P_ME    = 51;
  localparam int unsigned P_IR    = 58;
  localparam int unsigned P_DR    = 59;

  localparam int unsigned N_PR_FORCED = 3;
  localparam int unsigned PR_FORCED [N_PR_FORCED] = '{P_EE, P_IR, P_DR};

  typedef logic [XLEN-1:0] word_t;

  function automatic int unsigned ix(input int unsigned pos);
    return XLEN - 1 - pos;
  endfunction
endpackage

// File: rtl/rfi_status_merge.sv
module rfi_status_merge
  import rfi_pkg::*;
(
  input  word_t cur_i,
  input  word_t saved_i,
  output word_t merged_o
);
  localparam int unsigned TS_MSB = XLEN - 1 - P_TS_HI;
  localparam int unsigned TS_LSB = XLEN - 1 - P_TS_LO;
  localparam int unsigned HV_IX  = XLEN - 1 - P_HV;
  localparam int unsigned ME_IX  = XLEN - 1 - P_ME;
  localparam int unsigned PR_IX  = XLEN - 1 - P_PR;

  logic [TS_MSB-TS_LSB:0] cur_ts, saved_ts;
  logic keep_ts;

  assign cur_ts   = cur_i[TS_MSB:TS_LSB];
  assign saved_ts = saved_i[TS_MSB:TS_LSB];
  assign keep_ts  = (cur_ts == 3'b010) && (saved_ts == 3'b000);

  always_comb begin
    merged_o        = saved_i;
    merged_o[ME_IX] = cur_i[HV_IX] ? saved_i[ME_IX] : cur_i[ME_IX];
    merged_o[HV_IX] = cur_i[HV_IX] & saved_i[HV_IX];
    if (keep_ts) merged_o[TS_MSB:TS_LSB] = cur_ts;
    for (int k = 0; k < N_PR_FORCED; k++) begin
      merged_o[ix(PR_FORCED[k])] = saved_i[ix(PR_FORCED[k])] | saved_i[PR_IX];
    end
  end
endmodule

// File: rtl/rfi_target_calc.sv
module rfi_target_calc
  import rfi_pkg::*;
#(
  parameter int unsigned ALIGN_BITS  = 2,
  parameter int unsigned NARROW_BITS = 32
) (
  input  word_t ret_addr_i,
  input  logic  wide_i,
  output word_t nia_o
);
  always_comb begin
    nia_o = ret_addr_i;
    nia_o[ALIGN_BITS-1:0] = '0;
    if (!wide_i) nia_o[XLEN-1:NARROW_BITS] = '0;
  end
endmodule

// File: rtl/rfi_restore.sv
module rfi_restore
  import rfi_pkg::*;
#(
  parameter int unsigned ALIGN_BITS  = 2,
  parameter int unsigned NARROW_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [63:0] cur_msr_i,
  input  logic [63:0] srr1_i,
  input  logic [63:0] srr0_i,
  output logic [63:0] msr_o,
  output logic        msr_vld_o,
  output logic [63:0] nia_o,
  output logic        nia_vld_o
);
  localparam int unsigned SF_IX  = XLEN - 1 - P_SF;
  localparam int unsigned HV_IX  = XLEN - 1 - P_HV;
  localparam int unsigned ME_IX  = XLEN - 1 - P_ME;
  localparam int unsigned PR_IX  = XLEN - 1 - P_PR;
  localparam int unsigned EE_IX  = XLEN - 1 - P_EE;
  localparam int unsigned IR_IX  = XLEN - 1 - P_IR;
  localparam int unsigned DR_IX  = XLEN - 1 - P_DR;
  localparam int unsigned TS_MSB = XLEN - 1 - P_TS_HI;
  localparam int unsigned TS_LSB = XLEN - 1 - P_TS_LO;

  function automatic word_t copy_mask();
    word_t m;
    m = '1;
    m[ME_IX] = 1'b0; m[HV_IX] = 1'b0; m[EE_IX] = 1'b0;
    m[IR_IX] = 1'b0; m[DR_IX] = 1'b0;
    m[TS_MSB:TS_LSB] = '0;
    return m;
  endfunction
  localparam word_t COPY_MASK = copy_mask();

  word_t msr_next, nia_next;

  rfi_status_merge u_merge (
    .cur_i    (cur_msr_i),
    .saved_i  (srr1_i),
    .merged_o (msr_next)
  );

  rfi_target_calc #(
    .ALIGN_BITS  (ALIGN_BITS),
    .NARROW_BITS (NARROW_BITS)
  ) u_target (
    .ret_addr_i (srr0_i),
    .wide_i     (msr_next[SF_IX]),
    .nia_o      (nia_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr_o     <= '0;
      nia_o     <= '0;
      msr_vld_o <= 1'b0;
      nia_vld_o <= 1'b0;
    end else begin
      msr_vld_o <= start_i;
      nia_vld_o <= start_i;
      if (start_i) begin
        msr_o <= msr_next;
        nia_o <= nia_next;
      end
    end
  end

  AST_ME_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> msr_o[ME_IX] == ($past(cur_msr_i[HV_IX]) ? $past(srr1_i[ME_IX])
                                                          : $past(cur_msr_i[ME_IX]))); // R1
  AST_HV_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> msr_o[HV_IX] == ($past(cur_msr_i[HV_IX]) & $past(srr1_i[HV_IX]))); // R2
  AST_TS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> msr_o[TS_MSB:TS_LSB] ==
      ((($past(cur_msr_i[TS_MSB:TS_LSB]) == 3'b010) && ($past(srr1_i[TS_MSB:TS_LSB]) == 3'b000))
        ? 3'b010 : $past(srr1_i[TS_MSB:TS_LSB]))); // R3
  AST_EE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> msr_o[EE_IX] == ($past(srr1_i[EE_IX]) | $past(srr1_i[PR_IX]))); // R4
  AST_XLATE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (msr_o[IR_IX] == ($past(srr1_i[IR_IX]) | $past(srr1_i[PR_IX]))) &&
                (msr_o[DR_IX] == ($past(srr1_i[DR_IX]) | $past(srr1_i[PR_IX])))); // R5
  AST_STRAIGHT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ((msr_o ^ $past(srr1_i)) & COPY_MASK) == '0); // R6
  AST_NIA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    nia_vld_o |-> nia_o[ALIGN_BITS-1:0] == '0); // R7
  AST_NIA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (nia_vld_o && !msr_o[SF_IX]) |-> nia_o[XLEN-1:NARROW_BITS] == '0); // R8
  AST_NIA_LOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> nia_o[NARROW_BITS-1:ALIGN_BITS] == $past(srr0_i[NARROW_BITS-1:ALIGN_BITS])); // R7
  AST_VLD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    msr_vld_o == nia_vld_o); // R9
  AST_VLD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> msr_vld_o); // R9
  AST_VLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !msr_vld_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(msr_o) && $stable(nia_o)); // R10
endmodule

// File: tb/rfi_restore_bench.sv
`timescale 1ns/1ps
module rfi_restore_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] cur_msr_i = '0, srr1_i = '0, srr0_i = '0;
  logic [63:0] msr_o, nia_o;
  logic        msr_vld_o, nia_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] q_msr [$];
  logic [63:0] q_nia [$];
  logic [63:0] last_msr = '0, last_nia = '0;
  logic        exp_vld = 1'b0;

  always #10 clk = ~clk;

  rfi_restore u_rfi_restore (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cur_msr_i(cur_msr_i), .srr1_i(srr1_i), .srr0_i(srr0_i),
    .msr_o(msr_o), .msr_vld_o(msr_vld_o), .nia_o(nia_o), .nia_vld_o(nia_vld_o)
  );

  function automatic logic [63:0] model_msr(input logic [63:0] c, input logic [63:0] s);
    logic [63:0] m;
    m = s;
    m[12] = c[60] ? s[12] : c[12];
    m[60] = c[60] & s[60];
    if (c[34:32] == 3'b010 && s[34:32] == 3'b000) m[34:32] = 3'b010;
    m[15] = s[15] | s[14];
    m[5]  = s[5] | s[14];
    m[4]  = s[4] | s[14];
    return m;
  endfunction

  function automatic logic [63:0] model_nia(input logic [63:0] a, input logic sf);
    logic [63:0] n;
    n = a;
    n[1:0] = 2'b00;
    if (!sf) n[63:32] = '0;
    return n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] c, input logic [63:0] s1, input logic [63:0] s0);
    logic [63:0] em;
    @(negedge clk);
    cur_msr_i = c; srr1_i = s1; srr0_i = s0; start_i = 1'b1;
    em = model_msr(c, s1);
    q_msr.push_back(em);
    q_nia.push_back(model_nia(s0, s1[63]));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      cur_msr_i = {$urandom, $urandom};
      srr1_i = {$urandom, $urandom};
      srr0_i = {$urandom, $urandom};
    end
  endtask

  // monitor: expected valid from the strobe seen at the edge
  always @(posedge clk) exp_vld <= rst_n && start_i;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 msr_vld", {63'd0, msr_vld_o}, {63'd0, exp_vld});
      check("R9 nia_vld", {63'd0, nia_vld_o}, {63'd0, exp_vld});
      if (msr_vld_o) begin
        if (q_msr.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected result actual=%h expected=none", msr_o);
        end else begin
          last_msr = q_msr.pop_front();
          last_nia = q_nia.pop_front();
          check("R1-merge status (R2 R3 R4 R5 R6)", msr_o, last_msr);
          check("R7/R8 fetch address", nia_o, last_nia);
        end
      end else begin
        check("R10 status hold", msr_o, last_msr);
        check("R10 address hold", nia_o, last_nia);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] c, s;
    repeat (3) @(negedge clk);
    check("R10 reset msr", msr_o, 64'd0);
    check("R10 reset nia", nia_o, 64'd0);
    check("R9 reset valid", {62'd0, msr_vld_o, nia_vld_o}, 64'd0);
    rst_n = 1'b1;
    idle(2);
    // R1: hypervisor on, ME from saved; off, ME kept
    issue(64'h1000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_1003);
    issue(64'h0000_0000_0000_1000, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_2007);
    idle(1);
    // R2: hypervisor both set, only saved set
    issue(64'h1000_0000_0000_0000, 64'h9000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(64'h0000_0000_0000_0000, 64'h9000_0000_0000_0000, 64'h1234_5678_9ABC_DEF3);
    idle(2);
    // R3: protected pair, and its near misses
    issue(64'h0000_0002_0000_0000, 64'h0000_0000_0000_0000, 64'h0);
    issue(64'h0000_0002_0000_0000, 64'h0000_0001_0000_0000, 64'h4);
    issue(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h8);
    issue(64'h0000_0003_0000_0000, 64'h0000_0000_0000_0000, 64'hC);
    idle(1);
    // R4 R5: problem state forces EE IR DR
    issue(64'h0, 64'h0000_0000_0000_4000, 64'h0000_0000_8000_0001);
    issue(64'h0, 64'h0000_0000_0000_8030, 64'h0000_0000_8000_0002);
    idle(1);
    // R6 R8: wide vs narrow with upper address bits
    issue(64'h0, 64'h8000_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00F);
    issue(64'h0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_CAFE_F00F);
    idle(3);
    for (int i = 0; i < 400; i++) begin
      c = {$urandom, $urandom};
      s = {$urandom, $urandom};
      if (i % 4 == 0) begin c[34:32] = 3'b010; s[34:32] = 3'b000; end
      if (i % 3 == 0) s[14] = 1'b0;
      issue(c, s, {$urandom, $urandom});
      if (i % 5 == 0) idle(1 + (i % 3));
    end
    idle(4);
    check("R9 queue drained", 64'(q_msr.size()), 64'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule